// File: doc/BRIEF.md
# Dual-Input Cascadable Up/Down Counter

This block is a binary counter with two count pulse inputs, one for counting up and one for counting down. A free-running system clock samples both inputs. A count happens on the first system-clock edge at which a rising transition of a pulse input is seen, so the whole design runs in a single clock domain.

The counter has the following controls and outputs:
- A master clear, which has the highest priority.
- An active-low parallel load from a data input.
- A carry output and a borrow output, both active-low.

While the count sits at its upper or lower limit, each of these outputs copies the low phase of its own pulse input. It can therefore feed the matching pulse input of the next, more significant stage in a chain of counters.

The counter width is a parameter; the default is 4 bits, which counts modulo 16.

Top module: `updn_pulse_counter`

## Requirements
- R1: On a system-clock edge where `up_pulse` has risen (high now, low at the previous edge), `dn_pulse` is high and has not risen, `clr` is low and `load_n` is high, `count` increments by one. The value 15 wraps to 0.
- R2: On a system-clock edge where `dn_pulse` has risen, `up_pulse` is high and has not risen, `clr` is low and `load_n` is high, `count` decrements by one. The value 0 wraps to 15.
- R3: `clr` high at a system-clock edge makes `count` 0 after that edge, whatever `load_n`, `data_in` and both pulse inputs are doing.
- R4: `load_n` low with `clr` low at a system-clock edge copies `data_in` into `count`, whatever the pulse inputs are doing.
- R5: `carry_n` is low exactly when `clr` is low, `count` is 15 and `up_pulse` is low. It goes high again as soon as `up_pulse` returns high.
- R6: `borrow_n` is low exactly when `clr` is low, `count` is 0 and `dn_pulse` is low.
- R7: `count` holds its value in two cases: both pulse inputs rise at the same edge, or one pulse input rises while the other is low.
- R8: Suppose a pulse input is low while clear or load is active and stays low afterwards. Its first rising transition after release is counted.
- R9: The synchronous reset `rst` sets `count` to 0 and treats both pulse inputs as previously high. A pulse input held high through reset is therefore not counted.
- R10: Falling transitions of the pulse inputs, and cycles without any transition, leave `count` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every input |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Master clear, active high, highest priority |
| load_n | input | 1 | Parallel load enable, active low |
| data_in | input | WIDTH | Parallel load value |
| up_pulse | input | 1 | Count-up pulse input, counted on its rising transition |
| dn_pulse | input | 1 | Count-down pulse input, counted on its rising transition |
| count | output | WIDTH | Registered counter value |
| carry_n | output | 1 | Upper-limit terminal output, active low |
| borrow_n | output | 1 | Lower-limit terminal output, active low |

## Verification
The assertions assume that both pulse inputs and all controls are synchronous to the system clock and are stable around each sampling edge. Each pulse level must last at least one full system-clock period so that every transition is seen. The bench meets this by changing all inputs only on falling clock edges and by holding each pulse phase for at least one full period. It then sweeps every load value through an up pulse and a down pulse. After that it applies directed sequences for simultaneous edges, blocked edges, clear and load priority, and edges that arrive after a release.

// File: rtl/updn_cnt_pkg.sv
package updn_cnt_pkg;

  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_CLEAR = 3'd1,
    OP_LOAD  = 3'd2,
    OP_INC   = 3'd3,
    OP_DEC   = 3'd4
  } cnt_op_e;

  localparam int LANE_UP = 0;
  localparam int LANE_DN = 1;
  localparam int NUM_LANES = 2;

endpackage

// File: rtl/updn_edge_det.sv
module updn_edge_det #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] lvl,
  output logic [LANES-1:0] rise
);

  logic [LANES-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '1;
    else     prev_q <= lvl;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign rise[i] = lvl[i] & ~prev_q[i];

    // R1 R2: a detected rise needs the input low at the previous edge
    rise_from_low_chk: assert property (@(posedge clk) disable iff (rst)
      rise[i] |-> !$past(lvl[i]));

    // R10: a rise is never reported two edges in a row
    rise_single_chk: assert property (@(posedge clk) disable iff (rst)
      rise[i] |=> !rise[i]);
  end

endmodule

// File: rtl/updn_op_decode.sv
module updn_op_decode
  import updn_cnt_pkg::*;
(
  input  logic    clr,
  input  logic    load_n,
  input  logic    up_rise,
  input  logic    dn_rise,
  input  logic    up_lvl,
  input  logic    dn_lvl,
  output cnt_op_e op
);

  always_comb begin
    if (clr)                             op = OP_CLEAR;
    else if (!load_n)                    op = OP_LOAD;
    else if (up_rise && !dn_rise && dn_lvl) op = OP_INC;
    else if (dn_rise && !up_rise && up_lvl) op = OP_DEC;
    else                                 op = OP_HOLD;
  end

endmodule

// File: rtl/updn_cnt_reg.sv
module updn_cnt_reg
  import updn_cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  cnt_op_e          op,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] cnt_q
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] cnt_d;

  always_comb begin
    unique case (op)
      OP_CLEAR: cnt_d = '0;
      OP_LOAD:  cnt_d = load_val;
      OP_INC:   cnt_d = cnt_q + ONE;
      OP_DEC:   cnt_d = cnt_q - ONE;
      default:  cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  // R10: holding keeps the register unchanged
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_HOLD) |=> $stable(cnt_q));

endmodule

// File: rtl/updn_term_gen.sv
module updn_term_gen #(
  parameter int WIDTH     = 4,
  parameter bit MATCH_MAX = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [WIDTH-1:0] cnt_q,
  input  logic             pulse_lvl,
  output logic             tc_n
);

  localparam logic [WIDTH-1:0] LIMIT = MATCH_MAX ? {WIDTH{1'b1}} : {WIDTH{1'b0}};

  logic at_limit;

  assign at_limit = (cnt_q == LIMIT);
  assign tc_n     = ~(at_limit & ~pulse_lvl & ~clr);

  // R5 R6: the terminal output only falls while its pulse input is low
  tc_fall_low_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(tc_n) |-> !pulse_lvl);

  // R5 R6: a high pulse input always releases the terminal output
  tc_release_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_lvl |-> tc_n);

  // R3: clear keeps the terminal output inactive
  tc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |-> tc_n);

endmodule

// File: rtl/updn_pulse_counter.sv
module updn_pulse_counter
  import updn_cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load_n,
  input  logic [WIDTH-1:0] data_in,
  input  logic             up_pulse,
  input  logic             dn_pulse,
  output logic [WIDTH-1:0] count,
  output logic             carry_n,
  output logic             borrow_n
);

  logic [NUM_LANES-1:0] lvl;
  logic [NUM_LANES-1:0] rise;
  logic [NUM_LANES-1:0] tc_n;
  cnt_op_e              op;

  assign lvl[LANE_UP] = up_pulse;
  assign lvl[LANE_DN] = dn_pulse;

  updn_edge_det #(.LANES(NUM_LANES)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (lvl),
    .rise (rise)
  );

  updn_op_decode u_dec (
    .clr     (clr),
    .load_n  (load_n),
    .up_rise (rise[LANE_UP]),
    .dn_rise (rise[LANE_DN]),
    .up_lvl  (up_pulse),
    .dn_lvl  (dn_pulse),
    .op      (op)
  );

  updn_cnt_reg #(.WIDTH(WIDTH)) u_reg (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .load_val (data_in),
    .cnt_q    (count)
  );

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_term
    updn_term_gen #(.WIDTH(WIDTH), .MATCH_MAX(i == LANE_UP)) u_term (
      .clk       (clk),
      .rst       (rst),
      .clr       (clr),
      .cnt_q     (count),
      .pulse_lvl (lvl[i]),
      .tc_n      (tc_n[i])
    );
  end

  assign carry_n  = tc_n[LANE_UP];
  assign borrow_n = tc_n[LANE_DN];

  // R3
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0));

  // R4
  load_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !load_n) |=> (count == $past(data_in)));

  // R1
  up_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && load_n && rise[LANE_UP] && !rise[LANE_DN] && dn_pulse)
      |=> (count == WIDTH'($past(count) + 1'b1)));

  // R2
  dn_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && load_n && rise[LANE_DN] && !rise[LANE_UP] && up_pulse)
      |=> (count == WIDTH'($past(count) - 1'b1)));

  // R7
  both_rise_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && load_n && rise[LANE_UP] && rise[LANE_DN]) |=> $stable(count));

  // R7
  blocked_rise_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && load_n && ((rise[LANE_UP] && !dn_pulse) || (rise[LANE_DN] && !up_pulse)))
      |=> $stable(count));

endmodule

// File: tb/tb_updn_pulse_counter.sv
module tb_updn_pulse_counter;

  localparam int W = 4;
  localparam int M = 1 << W;

  logic         clk = 1'b0;
  logic         rst;
  logic         clr;
  logic         load_n;
  logic [W-1:0] data_in;
  logic         up_pulse;
  logic         dn_pulse;
  logic [W-1:0] count;
  logic         carry_n;
  logic         borrow_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  updn_pulse_counter #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .clr(clr), .load_n(load_n), .data_in(data_in),
    .up_pulse(up_pulse), .dn_pulse(dn_pulse),
    .count(count), .carry_n(carry_n), .borrow_n(borrow_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  task automatic load(input int v);
    @(negedge clk); load_n = 1'b0; data_in = W'(v);
    @(negedge clk); load_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1; clr = 1'b0; load_n = 1'b1; data_in = '0;
    up_pulse = 1'b1; dn_pulse = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state, high inputs through reset are not counted
    chk("R9 count", count, 0);
    chk("R9 carry_n", carry_n, 1);
    chk("R9 borrow_n", borrow_n, 1);

    for (int v = 0; v < M; v++) begin
      load(v);
      @(negedge clk);
      chk("R4 load", count, v);
      up_pulse = 1'b0;
      #1 chk("R5 carry_n low phase", carry_n, (v == M-1) ? 0 : 1);
      @(negedge clk);
      chk("R10 falling edge holds", count, v);
      up_pulse = 1'b1;
      #1 chk("R5 carry_n released", carry_n, 1);
      @(negedge clk);
      chk("R1 increment", count, (v + 1) % M);

      load(v);
      @(negedge clk);
      dn_pulse = 1'b0;
      #1 chk("R6 borrow_n low phase", borrow_n, (v == 0) ? 0 : 1);
      @(negedge clk);
      dn_pulse = 1'b1;
      @(negedge clk);
      chk("R2 decrement", count, (v + M - 1) % M);
    end

    // R3: clear beats load and counting; terminal output forced high
    load(15);
    @(negedge clk);
    clr = 1'b1; load_n = 1'b0; data_in = 4'd5; up_pulse = 1'b0;
    #1 chk("R3 carry_n forced high by clear", carry_n, 1);
    @(negedge clk);
    up_pulse = 1'b1;
    @(negedge clk);
    chk("R3 clear priority", count, 0);
    clr = 1'b0; load_n = 1'b1;
    @(negedge clk);

    // R4: load wins over a simultaneous count edge
    up_pulse = 1'b0;
    @(negedge clk);
    load_n = 1'b0; data_in = 4'd9; up_pulse = 1'b1;
    @(negedge clk);
    load_n = 1'b1;
    @(negedge clk);
    chk("R4 load over edge", count, 9);

    // R7: simultaneous rises hold
    up_pulse = 1'b0; dn_pulse = 1'b0;
    @(negedge clk);
    up_pulse = 1'b1; dn_pulse = 1'b1;
    @(negedge clk);
    chk("R7 both rise", count, 9);

    // R7: up rise while down input is low holds
    up_pulse = 1'b0; dn_pulse = 1'b0;
    @(negedge clk);
    up_pulse = 1'b1;
    @(negedge clk);
    chk("R7 blocked up", count, 9);
    dn_pulse = 1'b1;
    @(negedge clk);
    chk("R7 down rise while up high counts", count, 8);

    // R8: input low through clear, rise after release is counted
    up_pulse = 1'b0; clr = 1'b1;
    repeat (2) @(negedge clk);
    clr = 1'b0;
    repeat (2) @(negedge clk);
    up_pulse = 1'b1;
    @(negedge clk);
    chk("R8 after clear", count, 1);

    // R8: input low through load, rise after release is counted
    dn_pulse = 1'b0; load_n = 1'b0; data_in = 4'd7;
    repeat (2) @(negedge clk);
    load_n = 1'b1;
    @(negedge clk);
    dn_pulse = 1'b1;
    @(negedge clk);
    chk("R8 after load", count, 6);

    // R10: idle cycles hold
    repeat (5) @(negedge clk);
    chk("R10 idle", count, 6);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule